// File: doc/BRIEF.md
# Cascadable Programmable Up-Counter

A synchronous up-counter, four bits wide by default, that can be preset from a parallel data word and chained with identical stages. Every state change other than an asynchronous clear happens on the rising clock edge. Two count-enable inputs must both be high for the value to advance. The carry output flags the terminal count, and only the second enable gates it. The carry is combinational, so a chain of stages on a shared clock needs no glue logic: each stage's carry drives the next stage's carry-enable input.

Two build-time parameters choose the variant. The modulus is either binary, counting 0 to 15, or decade, counting 0 to 9. The clear input is active-low and takes effect either at the next clock edge or immediately. Clear has the highest priority, then load, then count, then hold.

Top module: `cascade_counter`

## Requirements
- R1: With synchronous clear, `clr_n` low at a rising edge makes `count` zero after that edge, whatever `ld_n`, `din` and the enables are. Between edges the count is unchanged.
- R2: With asynchronous clear, `clr_n` low forces `count` to zero at once, without a clock edge, and holds it at zero while low.
- R3: `ld_n` low at a rising edge (clear inactive) makes `count` equal to `din` after that edge, whatever the enables are.
- R4: With `ld_n` high and clear inactive, `count` increases by one at a rising edge only when `cnt_en` and `carry_en` are both high. Otherwise it holds.
- R5: In binary mode, an enabled edge at 15 gives 0.
- R6: In decade mode, an enabled edge at 9 gives 0.
- R7: `carry_out` is high exactly when `carry_en` is high and `count` equals the terminal value (9 decade, 15 binary). It follows `carry_en` without a clock edge.
- R8: In decade mode, a loaded value from 10 to 15 increments by one per enabled edge, goes from 15 to 0, and never raises `carry_out`.
- R9: Enable changes between clock edges have no effect. Only their level at the rising edge counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Active-low clear (synchronous or asynchronous by parameter) |
| ld_n | input | 1 | Active-low parallel load |
| din | input | WIDTH | Parallel preset value |
| cnt_en | input | 1 | Count enable, affects counting only |
| carry_en | input | 1 | Count enable that also gates the carry |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal-count flag for the next stage |

## Verification
A wrong next-state value shows on `count` right after the edge that stores it. A wrong wrap point shows within one enabled edge of the terminal value, as a count of 10 or a missing return to 0. A wrong carry decode is visible in the same cycle, and also with no clock edge at all when `carry_en` is toggled. A clear handled in the wrong style shows between edges: `count` is either already zero when it should still hold its value, or still holds its value when it should already be zero.

// File: rtl/cascade_counter_pkg.sv
// Shared types for the cascadable counter: modulus and clear-style selectors
// and the terminal-value helper. Assumes widths of at least four bits when
// the decade modulus is chosen.
package cascade_counter_pkg;

    typedef enum logic {
        MOD_BINARY = 1'b0,
        MOD_DECADE = 1'b1
    } modulus_e;

    typedef enum logic {
        CLR_SYNC  = 1'b0,
        CLR_ASYNC = 1'b1
    } clear_e;

    // Highest count value reached before wrapping to zero.
    function automatic int unsigned last_value(modulus_e m, int unsigned w);
        return (m == MOD_DECADE) ? 32'd9 : ((32'd1 << w) - 32'd1);
    endfunction

endpackage

// File: rtl/cascade_counter_next.sv
// Next-state selector. Picks between the preset word, the incremented count
// and the held count. Clear is applied by the state register, not here.
// Assumes adv is already the AND of both count enables.
module cascade_counter_next
    import cascade_counter_pkg::*;
#(
    parameter int unsigned WIDTH   = 4,
    parameter modulus_e    MODULUS = MOD_DECADE
) (
    input  logic [WIDTH-1:0] q,
    input  logic             ld_n,
    input  logic [WIDTH-1:0] din,
    input  logic             adv,
    output logic [WIDTH-1:0] d
);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(last_value(MODULUS, WIDTH));

    logic [WIDTH-1:0] inc;

    generate
        if (MODULUS == MOD_DECADE) begin : g_decade
            // Increment with a wrap at the decade terminal. Out-of-range
            // values fall through to the plain adder and wrap at 2**WIDTH.
            always_comb inc = (q == LAST) ? '0 : q + 1'b1;
        end else begin : g_binary
            // Plain increment that wraps naturally.
            always_comb inc = q + 1'b1;
        end
    endgenerate

    // Priority: load, then count, then hold.
    always_comb begin
        if (!ld_n) begin
            d = din;
        end else if (adv) begin
            d = inc;
        end else begin
            d = q;
        end
    end

endmodule

// File: rtl/cascade_counter_state.sv
// Count register. The clear style parameter picks between a clear sampled
// at the clock edge and a clear that acts as soon as it goes low.
module cascade_counter_state
    import cascade_counter_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter clear_e      CLEAR = CLR_SYNC
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (CLEAR == CLR_ASYNC) begin : g_async
            // Register with an immediate, edge-independent clear.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end
        end else begin : g_sync
            // Register whose clear is sampled at the clock edge.
            always_ff @(posedge clk) begin
                if (!clr_n) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cascade_counter_carry.sv
// Terminal-count detector. Combinational, so that a carry-enable change
// reaches the carry output without waiting for a clock edge.
module cascade_counter_carry
    import cascade_counter_pkg::*;
#(
    parameter int unsigned WIDTH   = 4,
    parameter modulus_e    MODULUS = MOD_DECADE
) (
    input  logic [WIDTH-1:0] q,
    input  logic             gate,
    output logic             carry
);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(last_value(MODULUS, WIDTH));

    // Flag the terminal value, qualified by the carry enable.
    always_comb carry = gate && (q == LAST);

endmodule

// File: rtl/cascade_counter.sv
// Cascadable programmable up-counter. Priority is clear, load, count, hold.
// Counting needs both enables high; only carry_en gates the carry.
// Assumes the inputs are synchronous to clk, apart from clr_n in the
// asynchronous-clear variant.
module cascade_counter
    import cascade_counter_pkg::*;
#(
    parameter int unsigned WIDTH   = 4,
    parameter modulus_e    MODULUS = MOD_DECADE,
    parameter clear_e      CLEAR   = CLR_SYNC
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ld_n,
    input  logic [WIDTH-1:0] din,
    input  logic             cnt_en,
    input  logic             carry_en,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] d;
    logic             adv;

    // Both enables must be high to advance.
    always_comb adv = cnt_en && carry_en;

    cascade_counter_next #(
        .WIDTH   (WIDTH),
        .MODULUS (MODULUS)
    ) u_next (
        .q    (q),
        .ld_n (ld_n),
        .din  (din),
        .adv  (adv),
        .d    (d)
    );

    cascade_counter_state #(
        .WIDTH (WIDTH),
        .CLEAR (CLEAR)
    ) u_state (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (d),
        .q     (q)
    );

    cascade_counter_carry #(
        .WIDTH   (WIDTH),
        .MODULUS (MODULUS)
    ) u_carry (
        .q     (q),
        .gate  (carry_en),
        .carry (carry_out)
    );

    // Drive the count output from the state register.
    always_comb count = q;

endmodule

// File: rtl/cascade_counter_chk.sv
// Property checker for the cascadable counter, bound into every instance.
module cascade_counter_chk
    import cascade_counter_pkg::*;
#(
    parameter int unsigned WIDTH   = 4,
    parameter modulus_e    MODULUS = MOD_DECADE,
    parameter clear_e      CLEAR   = CLR_SYNC
) (
    input logic             clk,
    input logic             clr_n,
    input logic             ld_n,
    input logic [WIDTH-1:0] din,
    input logic             cnt_en,
    input logic             carry_en,
    input logic [WIDTH-1:0] count,
    input logic             carry_out
);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(last_value(MODULUS, WIDTH));

    generate
        if (CLEAR == CLR_SYNC) begin : g_sync
            // R1: the edge after a sampled clear shows zero.
            assert_sync_clear_R1: assert property (@(posedge clk) disable iff (!clr_n)
                $past(!clr_n) |-> count == '0);
        end else begin : g_async
            // R2: while clear is low, no edge finds a nonzero count.
            assert_async_clear_R2: assert property (@(posedge clk)
                !clr_n |-> count == '0);
        end
        if (MODULUS == MOD_DECADE) begin : g_dec
            // R6: an enabled edge at 9 returns to zero.
            assert_decade_wrap_R6: assert property (@(posedge clk) disable iff (!clr_n)
                (ld_n && cnt_en && carry_en && count == LAST) |=> count == '0);
        end else begin : g_bin
            // R5: an enabled edge at the top value returns to zero.
            assert_binary_wrap_R5: assert property (@(posedge clk) disable iff (!clr_n)
                (ld_n && cnt_en && carry_en && count == LAST) |=> count == '0);
        end
    endgenerate

    // R3: a load takes the preset word.
    assert_load_R3: assert property (@(posedge clk) disable iff (!clr_n)
        !ld_n |=> count == $past(din));

    // R4: without both enables, the count holds.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && !(cnt_en && carry_en)) |=> $stable(count));

    // R7: the carry never rises without its enable.
    assert_carry_gated_R7: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> carry_en);

    // R7: the carry is high only at the terminal value.
    assert_carry_terminal_R7: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> count == LAST);

endmodule

bind cascade_counter cascade_counter_chk #(
    .WIDTH   (WIDTH),
    .MODULUS (MODULUS),
    .CLEAR   (CLEAR)
) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .ld_n      (ld_n),
    .din       (din),
    .cnt_en    (cnt_en),
    .carry_en  (carry_en),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/test_cascade_counter.sv
`timescale 1ns/1ps
module test_cascade_counter;
    import cascade_counter_pkg::*;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       ld_n = 1'b1;
    logic [3:0] din = 4'd0;
    logic       cnt_en = 1'b0;
    logic       carry_en = 1'b0;
    logic [3:0] dec_count, bin_count;
    logic       dec_carry, bin_carry;

    int applied = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    // Decade modulus, synchronous clear.
    cascade_counter #(.WIDTH(4), .MODULUS(MOD_DECADE), .CLEAR(CLR_SYNC)) i_cascade_counter (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din), .cnt_en(cnt_en),
        .carry_en(carry_en), .count(dec_count), .carry_out(dec_carry));

    // Binary modulus, asynchronous clear.
    cascade_counter #(.WIDTH(4), .MODULUS(MOD_BINARY), .CLEAR(CLR_ASYNC)) i_cascade_counter_bin (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din), .cnt_en(cnt_en),
        .carry_en(carry_en), .count(bin_count), .carry_out(bin_carry));

    task automatic check(input string what, input int act, input int exp);
        applied++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Row: clr_n, ld_n, din, cnt_en, carry_en, dec count, dec carry, bin count, bin carry
    localparam logic [17:0] VEC [14] = '{
        {1'b0, 1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0, 4'd0,  1'b0}, // R1 R2 reset state
        {1'b1, 1'b0, 4'd7,  1'b0, 1'b0, 4'd7,  1'b0, 4'd7,  1'b0}, // R3 load, enables low
        {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd8,  1'b0, 4'd8,  1'b0}, // R4 count
        {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd9,  1'b1, 4'd9,  1'b0}, // R7 decade terminal
        {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0, 4'd10, 1'b0}, // R6 decade wrap
        {1'b1, 1'b0, 4'd14, 1'b1, 1'b1, 4'd14, 1'b0, 4'd14, 1'b0}, // R3 load beats count
        {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd15, 1'b0, 4'd15, 1'b1}, // R8 no decade carry, R7 binary carry
        {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0, 4'd0,  1'b0}, // R5 R8 wrap from 15
        {1'b1, 1'b1, 4'd0,  1'b0, 1'b1, 4'd0,  1'b0, 4'd0,  1'b0}, // R4 hold, cnt_en low
        {1'b1, 1'b1, 4'd0,  1'b1, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0}, // R4 hold, carry_en low
        {1'b1, 1'b0, 4'd9,  1'b0, 1'b1, 4'd9,  1'b1, 4'd9,  1'b0}, // R3 R7 load terminal
        {1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd9,  1'b0, 4'd9,  1'b0}, // R7 carry gated off
        {1'b0, 1'b0, 4'd5,  1'b1, 1'b1, 4'd0,  1'b0, 4'd0,  1'b0}, // R1 R2 clear beats load
        {1'b1, 1'b0, 4'd15, 1'b0, 1'b1, 4'd15, 1'b0, 4'd15, 1'b1}  // R3 R7 R8
    };

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
            $finish;
        end
    end

    initial begin
        // Vector table walk
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            {clr_n, ld_n, din, cnt_en, carry_en} = VEC[i][17:10];
            @(posedge clk);
            #1;
            check($sformatf("vector %0d decade count", i), dec_count, VEC[i][9:6]);
            check($sformatf("vector %0d decade carry", i), dec_carry, VEC[i][5]);
            check($sformatf("vector %0d binary count", i), bin_count, VEC[i][4:1]);
            check($sformatf("vector %0d binary carry", i), bin_carry, VEC[i][0]);
        end

        // R9: enables high between edges but low at the edge do not count.
        @(negedge clk);
        ld_n = 1'b1; cnt_en = 1'b1; carry_en = 1'b1;
        #2 cnt_en = 1'b0;
        @(posedge clk); #1;
        check("R9 decade hold", dec_count, 15);
        check("R9 binary hold", bin_count, 15);

        // R7: carry follows carry_en with no clock edge.
        @(negedge clk);
        ld_n = 1'b0; din = 4'd9; carry_en = 1'b0;
        @(posedge clk); #1;
        check("R7 carry low while gated", dec_carry, 0);
        #1 carry_en = 1'b1;
        #1 check("R7 carry rises without edge", dec_carry, 1);
        #1 carry_en = 1'b0;
        #1 check("R7 carry falls without edge", dec_carry, 0);

        // R8: decade counter above 9 keeps counting, no carry.
        @(negedge clk);
        ld_n = 1'b0; din = 4'd10;
        @(posedge clk);
        @(negedge clk);
        ld_n = 1'b1; cnt_en = 1'b1; carry_en = 1'b1;
        @(posedge clk); #1;
        check("R8 decade 10 to 11", dec_count, 11);
        check("R8 decade carry at 11", dec_carry, 0);
        check("R4 binary 10 to 11", bin_count, 11);

        // R2 and R1: clear mid-cycle.
        @(negedge clk);
        cnt_en = 1'b0; carry_en = 1'b0; clr_n = 1'b0;
        #1;
        check("R2 async clear immediate", bin_count, 0);
        check("R1 sync clear waits for edge", dec_count, 11);
        @(posedge clk); #1;
        check("R1 sync clear at edge", dec_count, 0);
        @(negedge clk);
        clr_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

endmodule